// File: doc/BRIEF.md
# I2C Fan Speed and Duty Controller

This block is an I2C target for one cooling fan. It answers at a fixed 7-bit bus address and holds a small register map. A write to the control register turns the fan drive on or off. A write to the duty register sets how much of each PWM period the fan output spends high, as a percentage. A read of the control register returns its contents. A read of the speed register returns the fan speed in revolutions per second, measured from the tachometer input.

Both bus lines are oversampled on the system clock, and the block sees bus edges only through that sampling. The target pulls SDA low through an output-enable and otherwise leaves the line alone. It never holds SCL low. A transaction sends a register index byte first and then data bytes. After each data byte the register pointer moves on by one, so a single transfer can cover both registers.

The speed meter counts rising tachometer edges in a fixed window that lasts one second by default. It divides the count by the number of pulses per revolution and saturates the result to eight bits. The result is updated once per window.

Top module: `fanctl_top`

## Requirements
- R1: The block acknowledges 7-bit address 0x74 (write byte 0xE8, read byte 0xE9). It leaves any other address unacknowledged, and the data bytes that follow such an address change no register.
- R2: A data byte written to index 0x00 is stored whole in the control register, and a read of index 0x00 returns that byte.
- R3: A data byte written to index 0x01 sets the duty value, which comes out of reset as 80. While control bit 7 is set, the PWM output is high for duty × STEP_CYCLES system cycles in every period of 100 × STEP_CYCLES cycles.
- R4: While control bit 7 is clear, the PWM output stays low whatever the duty value.
- R5: A duty value of 0 keeps the enabled output low. Any duty value of 100 or more keeps the enabled output high for the whole period.
- R6: A read of index 0x01 returns the number of rising tachometer edges counted in the last complete window of WINDOW_CYCLES cycles, divided by PULSES_PER_REV (integer division).
- R7: The speed reading saturates at 255 when the divided count exceeds 255.
- R8: The register pointer takes its value from the first byte after a write address. It then advances by one after every data byte, whether that byte is written or read. A read that follows a repeated START begins at the pointer left by the write.
- R9: A read of any index other than 0x00 and 0x01 returns 0x00, and a write to such an index has no effect.
- R10: After reset the PWM output is low, SDA is released, and the control register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both bus lines and the tachometer input are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen at the pin |
| sda_i | input | 1 | I2C data line as seen at the pin |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain drive) |
| tach_i | input | 1 | Fan tachometer pulse input |
| pwm_o | output | 1 | Fan PWM drive |

## Verification
The bench tries the PWM path with both directed and seeded-random pairs of enable bit and duty value. Duty 0, 100 and values above 100 separate the clamp from a plain comparison. A cleared enable bit separates gating from duty handling. The high time is measured over one full period and compared with a figure computed in the bench.

The tachometer is driven with periods that divide the window exactly, so the expected count does not depend on where the window starts. One of those periods is fast enough to force saturation. Bus traffic is checked on the bus itself:
- a wrong address, to show the NACK and that the following bytes are ignored;
- multi-byte reads and writes, to show the pointer advancing;
- out-of-map indices, to show they read as zero.

// File: rtl/fanctl_pkg.sv
package fanctl_pkg;

   localparam int PWM_STEPS = 100;
   localparam int DATA_W    = 8;

   localparam logic [DATA_W-1:0] IDX_CTRL  = 8'h00;
   localparam logic [DATA_W-1:0] IDX_DUTY  = 8'h01;
   localparam logic [DATA_W-1:0] IDX_SPEED = 8'h01;

   localparam int CTRL_EN_BIT = 7;

   typedef enum logic [3:0] {
      TS_IDLE,
      TS_ADDR,
      TS_AACK,
      TS_REG,
      TS_RACK,
      TS_WR,
      TS_WACK,
      TS_RD,
      TS_RDACK
   } tgt_state_e;

endpackage

// File: rtl/fanctl_sync.sv
module fanctl_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 1) begin : g_bad
         $error("fanctl_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] pipe_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= RST_VAL;
            else        pipe_q <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
            else        pipe_q <= {pipe_q[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/fanctl_i2c_tgt.sv
module fanctl_i2c_tgt
   import fanctl_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h74,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   output logic              wr_stb_o,
   output logic [DATA_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [DATA_W-1:0] rd_addr_o,
   input  logic [DATA_W-1:0] rd_data_i
);

   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

   logic scl_s, sda_s, scl_q, sda_q;

   fanctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   fanctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   logic scl_rise, scl_fall, start_det, stop_det;
   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

   tgt_state_e        state_q;
   logic [CNT_W-1:0]  bit_cnt_q;
   logic [DATA_W-1:0] shreg_q;
   logic [DATA_W-1:0] ptr_q;
   logic              rw_q;
   logic              mack_q;
   logic              oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= TS_IDLE;
         bit_cnt_q <= '0;
         shreg_q   <= '0;
         ptr_q     <= '0;
         rw_q      <= 1'b0;
         mack_q    <= 1'b0;
         oe_q      <= 1'b0;
         wr_stb_o  <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
      end else begin
         wr_stb_o <= 1'b0;
         if (start_det) begin
            state_q   <= TS_ADDR;
            bit_cnt_q <= '0;
            oe_q      <= 1'b0;
         end else if (stop_det) begin
            state_q <= TS_IDLE;
            oe_q    <= 1'b0;
         end else begin
            unique case (state_q)
               TS_IDLE: ;
               TS_ADDR, TS_REG, TS_WR: begin
                  if (scl_rise) begin
                     shreg_q   <= {shreg_q[DATA_W-2:0], sda_s};
                     bit_cnt_q <= bit_cnt_q + 1'b1;
                  end else if (scl_fall && bit_cnt_q == LAST_BIT) begin
                     bit_cnt_q <= '0;
                     if (state_q == TS_ADDR) begin
                        if (shreg_q[DATA_W-1:1] == DEV_ADDR) begin
                           rw_q    <= shreg_q[0];
                           oe_q    <= 1'b1;
                           state_q <= TS_AACK;
                        end else begin
                           state_q <= TS_IDLE;
                        end
                     end else if (state_q == TS_REG) begin
                        ptr_q   <= shreg_q;
                        oe_q    <= 1'b1;
                        state_q <= TS_RACK;
                     end else begin
                        wr_stb_o  <= 1'b1;
                        wr_addr_o <= ptr_q;
                        wr_data_o <= shreg_q;
                        ptr_q     <= ptr_q + 1'b1;
                        oe_q      <= 1'b1;
                        state_q   <= TS_WACK;
                     end
                  end
               end
               TS_AACK: begin
                  if (scl_fall) begin
                     bit_cnt_q <= '0;
                     if (rw_q) begin
                        shreg_q <= rd_data_i;
                        oe_q    <= ~rd_data_i[DATA_W-1];
                        state_q <= TS_RD;
                     end else begin
                        oe_q    <= 1'b0;
                        state_q <= TS_REG;
                     end
                  end
               end
               TS_RACK, TS_WACK: begin
                  if (scl_fall) begin
                     oe_q    <= 1'b0;
                     state_q <= TS_WR;
                  end
               end
               TS_RD: begin
                  if (scl_rise) begin
                     bit_cnt_q <= bit_cnt_q + 1'b1;
                  end else if (scl_fall) begin
                     if (bit_cnt_q == LAST_BIT) begin
                        bit_cnt_q <= '0;
                        oe_q      <= 1'b0;
                        ptr_q     <= ptr_q + 1'b1;
                        state_q   <= TS_RDACK;
                     end else begin
                        shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
                        oe_q    <= ~shreg_q[DATA_W-2];
                     end
                  end
               end
               TS_RDACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        shreg_q <= rd_data_i;
                        oe_q    <= ~rd_data_i[DATA_W-1];
                        state_q <= TS_RD;
                     end else begin
                        oe_q    <= 1'b0;
                        state_q <= TS_IDLE;
                     end
                  end
               end
               default: state_q <= TS_IDLE;
            endcase
         end
      end
   end

   assign sda_oe_o  = oe_q;
   assign rd_addr_o = ptr_q;

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TS_IDLE) |-> !oe_q);                               // R1

   AST_PTR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |-> (ptr_q == wr_addr_o + 1'b1));                     // R8

endmodule

// File: rtl/fanctl_pwm.sv
module fanctl_pwm
   import fanctl_pkg::*;
#(
   parameter int STEP_CYCLES = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [DATA_W-1:0] duty_i,
   output logic              pwm_o
);

   localparam int PH_W = $clog2(PWM_STEPS);

   generate
      if (STEP_CYCLES < 1) begin : g_bad
         $error("fanctl_pwm: STEP_CYCLES must be at least 1");
      end
   endgenerate

   logic step_tick;

   generate
      if (STEP_CYCLES == 1) begin : g_nodiv
         assign step_tick = 1'b1;
      end else begin : g_div
         localparam int SW = $clog2(STEP_CYCLES);
         logic [SW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              pre_q <= '0;
            else if (pre_q == SW'(STEP_CYCLES - 1))  pre_q <= '0;
            else                                     pre_q <= pre_q + 1'b1;
         end
         assign step_tick = (pre_q == SW'(STEP_CYCLES - 1));
      end
   endgenerate

   logic [PH_W-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (step_tick) begin
         if (phase_q == PH_W'(PWM_STEPS - 1)) phase_q <= '0;
         else                                 phase_q <= phase_q + 1'b1;
      end
   end

   logic [DATA_W-1:0] duty_eff;
   assign duty_eff = (duty_i > DATA_W'(PWM_STEPS)) ? DATA_W'(PWM_STEPS) : duty_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm_o <= 1'b0;
      else        pwm_o <= en_i && (DATA_W'(phase_q) < duty_eff);
   end

   AST_PWM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !pwm_o);                                             // R4

   AST_PWM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && duty_i >= DATA_W'(PWM_STEPS)) |=> pwm_o);             // R5

   AST_PWM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_i == '0) |=> !pwm_o);                                    // R5

endmodule

// File: rtl/fanctl_tach.sv
module fanctl_tach
   import fanctl_pkg::*;
#(
   parameter int WINDOW_CYCLES  = 50_000_000,
   parameter int PULSES_PER_REV = 2,
   parameter int SYNC_STAGES    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tach_i,
   output logic [DATA_W-1:0] rps_o
);

   localparam int WW    = $clog2(WINDOW_CYCLES);
   localparam int EW_R  = $clog2(WINDOW_CYCLES + 1);
   localparam int EW    = (EW_R > DATA_W + 1) ? EW_R : DATA_W + 1;
   localparam logic [EW-1:0] SAT = EW'((1 << DATA_W) - 1);

   generate
      if (WINDOW_CYCLES < 2) begin : g_bad_win
         $error("fanctl_tach: WINDOW_CYCLES must be at least 2");
      end
      if (PULSES_PER_REV < 1) begin : g_bad_ppr
         $error("fanctl_tach: PULSES_PER_REV must be at least 1");
      end
   endgenerate

   logic tach_s, tach_q;

   fanctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tach_sync (
      .clk(clk), .rst_n(rst_n), .d(tach_i), .q(tach_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tach_q <= 1'b0;
      else        tach_q <= tach_s;
   end

   logic tach_rise;
   assign tach_rise = tach_s & ~tach_q;

   logic [WW-1:0] win_q;
   logic          win_end;
   assign win_end = (win_q == WW'(WINDOW_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       win_q <= '0;
      else if (win_end) win_q <= '0;
      else              win_q <= win_q + 1'b1;
   end

   logic [EW-1:0] edges_q, total, quot;
   assign total = edges_q + EW'(tach_rise);

   generate
      if (PULSES_PER_REV == 1) begin : g_ppr_one
         assign quot = total;
      end else begin : g_ppr_div
         assign quot = total / EW'(PULSES_PER_REV);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edges_q <= '0;
         rps_o   <= '0;
      end else if (win_end) begin
         edges_q <= '0;
         rps_o   <= (quot > SAT) ? SAT[DATA_W-1:0] : quot[DATA_W-1:0];
      end else begin
         edges_q <= total;
      end
   end

   AST_RPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |=> $stable(rps_o));                                  // R6

endmodule

// File: rtl/fanctl_top.sv
module fanctl_top
   import fanctl_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR       = 7'h74,
   parameter int         WINDOW_CYCLES  = 50_000_000,
   parameter int         PULSES_PER_REV = 2,
   parameter int         STEP_CYCLES    = 20,
   parameter int         SYNC_STAGES    = 2,
   parameter int         DUTY_RESET     = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe_o,
   input  logic tach_i,
   output logic pwm_o
);

   generate
      if (DUTY_RESET < 0 || DUTY_RESET > 255) begin : g_bad_duty
         $error("fanctl_top: DUTY_RESET must fit in one byte");
      end
   endgenerate

   logic              wr_stb;
   logic [DATA_W-1:0] wr_addr, wr_data, rd_addr, rd_data;
   logic [DATA_W-1:0] ctrl_q, duty_q, rps;

   fanctl_i2c_tgt #(.DEV_ADDR(DEV_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_tgt (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_oe_o(sda_oe_o), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr),
      .wr_data_o(wr_data), .rd_addr_o(rd_addr), .rd_data_i(rd_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         duty_q <= DATA_W'(DUTY_RESET);
      end else if (wr_stb) begin
         if (wr_addr == IDX_CTRL)      ctrl_q <= wr_data;
         else if (wr_addr == IDX_DUTY) duty_q <= wr_data;
      end
   end

   always_comb begin
      unique case (rd_addr)
         IDX_CTRL:  rd_data = ctrl_q;
         IDX_SPEED: rd_data = rps;
         default:   rd_data = '0;
      endcase
   end

   fanctl_pwm #(.STEP_CYCLES(STEP_CYCLES)) u_pwm (
      .clk(clk), .rst_n(rst_n), .en_i(ctrl_q[CTRL_EN_BIT]),
      .duty_i(duty_q), .pwm_o(pwm_o));

   fanctl_tach #(.WINDOW_CYCLES(WINDOW_CYCLES), .PULSES_PER_REV(PULSES_PER_REV),
                 .SYNC_STAGES(SYNC_STAGES)) u_tach (
      .clk(clk), .rst_n(rst_n), .tach_i(tach_i), .rps_o(rps));

   AST_CTRL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_addr == IDX_CTRL) |=> (ctrl_q == $past(wr_data)));   // R2

   AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_addr > IDX_DUTY) |=> ($stable(ctrl_q) && $stable(duty_q))); // R9

endmodule

// File: tb/tb_fanctl_top.sv
module tb_fanctl_top;

   localparam int Q    = 10;
   localparam int WIN  = 2000;
   localparam int STEP = 2;
   localparam int PER  = 100 * STEP;
   localparam int PPR  = 2;

   logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, tach = 1'b0;
   wire  sda_oe, pwm;
   wire  sda_bus = sda_m & ~sda_oe;

   always #10 clk = ~clk;

   fanctl_top #(.WINDOW_CYCLES(WIN), .PULSES_PER_REV(PPR), .STEP_CYCLES(STEP)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .sda_oe_o(sda_oe), .tach_i(tach), .pwm_o(pwm));

   int n_chk = 0, n_fail = 0, tach_half = 0, tach_cnt = 0;
   bit done = 1'b0;

   initial forever begin
      @(negedge clk);
      if (tach_half == 0) begin
         tach = 1'b0; tach_cnt = 0;
      end else begin
         tach_cnt++;
         if (tach_cnt >= tach_half) begin tach_cnt = 0; tach = ~tach; end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wq(); repeat (Q) @(negedge clk); endtask

   task automatic i2c_start();
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic wbyte(input logic [7:0] b, output bit nack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0;
      end
      wq(); sda_m = 1'b1; wq(); scl = 1'b1; wq(); nack = sda_bus; wq(); scl = 1'b0; wq();
   endtask

   task automatic rbyte(input bit mack, output logic [7:0] d);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(); scl = 1'b1; wq(); d[i] = sda_bus; wq(); scl = 1'b0;
      end
      wq(); sda_m = ~mack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); sda_m = 1'b1;
   endtask

   task automatic wr_regs(input logic [7:0] idx, input logic [7:0] d0,
                          input logic [7:0] d1, input int n);
      bit nk;
      i2c_start();
      wbyte(8'hE8, nk); chk("R1 address ack", nk, 0);
      wbyte(idx, nk);
      wbyte(d0, nk);
      if (n > 1) wbyte(d1, nk);
      i2c_stop();
   endtask

   task automatic rd_reg(input logic [7:0] idx, output logic [7:0] d);
      bit nk;
      i2c_start(); wbyte(8'hE8, nk); wbyte(idx, nk);
      i2c_start(); wbyte(8'hE9, nk); rbyte(1'b0, d); i2c_stop();
   endtask

   task automatic meas_pwm(output int hi);
      repeat (PER) @(negedge clk);
      hi = 0;
      repeat (PER) begin @(negedge clk); if (pwm) hi++; end
   endtask

   function automatic int exp_pwm(input bit en, input int duty);
      return en ? ((duty > 100) ? 100 : duty) * STEP : 0;
   endfunction

   function automatic int exp_rps(input int half);
      int v;
      if (half == 0) return 0;
      v = (WIN / (2 * half)) / PPR;
      return (v > 255) ? 255 : v;
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int hi, r_dummy;
      bit nk;
      int halves[5] = '{20, 50, 4, 1, 0};

      repeat (5) @(negedge clk);
      chk("R10 pwm in reset", pwm, 0);
      chk("R10 sda released in reset", sda_oe, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      rd_reg(8'h00, d); chk("R10 ctrl after reset", d, 0);
      meas_pwm(hi); chk("R4 disabled default", hi, 0);

      wr_regs(8'h00, 8'h80, 8'h00, 1);
      meas_pwm(hi); chk("R3 default duty 80", hi, exp_pwm(1, 80));

      wr_regs(8'h00, 8'h80, 8'd0, 2);
      meas_pwm(hi); chk("R5 duty zero", hi, 0);
      wr_regs(8'h01, 8'd100, 8'h00, 1);
      meas_pwm(hi); chk("R5 duty 100", hi, exp_pwm(1, 100));
      wr_regs(8'h01, 8'd200, 8'h00, 1);
      meas_pwm(hi); chk("R5 duty clamp", hi, exp_pwm(1, 200));
      wr_regs(8'h00, 8'h7F, 8'h00, 1);
      meas_pwm(hi); chk("R4 enable clear", hi, 0);

      wr_regs(8'h00, 8'h85, 8'd37, 2);
      meas_pwm(hi); chk("R8 write increment to duty", hi, exp_pwm(1, 37));
      i2c_start(); wbyte(8'hE8, nk); wbyte(8'h00, nk);
      i2c_start(); wbyte(8'hE9, nk);
      rbyte(1'b1, d); chk("R8 read idx0", d, 8'h85);
      rbyte(1'b1, d); chk("R8 read idx1 speed", d, 0);
      rbyte(1'b0, d); chk("R9 read idx2 zero", d, 0);
      i2c_stop();

      wr_regs(8'h05, 8'h33, 8'h00, 1);
      rd_reg(8'h05, d); chk("R9 out-of-map read", d, 0);
      rd_reg(8'h00, d); chk("R9 ctrl untouched", d, 8'h85);

      i2c_start(); wbyte(8'hA0, nk); chk("R1 foreign address nack", nk, 1);
      wbyte(8'h00, nk); wbyte(8'h11, nk); i2c_stop();
      rd_reg(8'h00, d); chk("R1 foreign write ignored", d, 8'h85);

      r_dummy = $urandom(32'd20240611);
      for (int k = 0; k < 6; k++) begin
         logic [7:0] c, du;
         c  = 8'($urandom);
         du = 8'($urandom % 128);
         wr_regs(8'h00, c, du, 2);
         meas_pwm(hi); chk("R3 random duty", hi, exp_pwm(c[7], du));
         rd_reg(8'h00, d); chk("R2 ctrl readback", d, c);
      end

      foreach (halves[j]) begin
         tach_half = halves[j];
         repeat (2 * WIN + 100) @(negedge clk);
         rd_reg(8'h01, d);
         if (exp_rps(halves[j]) == 255) chk("R7 speed saturation", d, 255);
         else                           chk("R6 speed reading", d, exp_rps(halves[j]));
      end

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule